// File: doc/BRIEF.md
# Open-Row DRAM Bank Command Sequencer

This block is the back end of a single-channel, single-rank memory controller. It takes one cache-block read request at a time as a byte address. It splits the address into row, bank and column fields and drives activate, read and precharge commands onto one shared command bus.

For every bank it remembers whether a row is open and which row that is. From this it picks the shortest legal command sequence for the request:

- **Closed bank:** activate, then read.
- **Open row hit:** read only.
- **Row conflict:** precharge, then activate, then read.

A 64-byte block is fetched as a burst of eight column reads, one per cycle, on the 64-bit data path.

Two address layouts are supported, selected per request:

- **Row-interleaved:** whole rows rotate across banks.
- **Block-interleaved:** consecutive 64-byte blocks rotate across banks.

Either layout can have its bank index scrambled with low row bits. Fixed gaps, set by parameters, are kept between precharge and activate and between activate and the first read. Data handling, refresh and reordering of several requests are left to the surrounding logic.

Top module: `bank_cmd_seq`

## Requirements
- R1: After reset every bank is closed, `req_ready_o` is 1 and `cmd_o` is NOP. Command codes are: 0 NOP, 1 activate, 2 read, 3 precharge.
- R2: With `map_sel_i`=0 (row-interleaved) the address decodes as follows: row = addr[30:17], bank = addr[16:14], column = addr[13:3].
- R3: With `map_sel_i`=1 (block-interleaved) the address decodes as follows: row = addr[30:17], high column = addr[16:9], bank = addr[8:6], low column = addr[5:3]. Addresses 64 bytes apart therefore fall in consecutive banks.
- R4: With `xor_en_i`=1 the bank index used is the decoded bank field XOR row[2:0].
- R5: A request to a closed bank gives an activate in the cycle after acceptance, carrying the bank and row. The first read follows exactly T_RCD cycles after the activate.
- R6: A request to the row already open in its bank gives no activate and no precharge. Its first read comes in the cycle after acceptance.
- R7: A request to a bank whose open row differs gives a precharge to that bank in the cycle after acceptance. An activate of the new row follows exactly T_RP cycles after the precharge, and the first read follows T_RCD cycles after the activate.
- R8: Each request issues eight reads on consecutive cycles. Their column is {column[10:3], k} for k = 0 to 7 in rising order, and each carries the request's bank and row.
- R9: At most one command is issued per cycle. `req_ready_o` is 1 only when no command sequence is in progress. A request presented while `req_ready_o` is 0 is ignored and changes no bank state.
- R10: Bank state is kept per bank. A precharge closes only its own bank, and an activate leaves that bank open on the new row. Opening another bank does not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | 31 | Byte address of the block |
| map_sel_i | input | 1 | 0 row-interleaved, 1 block-interleaved |
| xor_en_i | input | 1 | Enable bank hashing with row bits |
| req_ready_o | output | 1 | Sequencer idle, request taken at this edge |
| cmd_o | output | 2 | Command code (0 NOP, 1 ACT, 2 RD, 3 PRE) |
| cmd_bank_o | output | 3 | Bank of the command |
| cmd_row_o | output | 14 | Row of the command |
| cmd_col_o | output | 11 | Column of a read |

## Verification
The hardest situation to reach is a row conflict whose correctness depends on history: a bank must still hold a row opened several requests earlier, after other banks have been opened in between. The stimulus builds this up deliberately. It opens a row, revisits the bank for a hit, forces a conflict, touches a different bank, then returns to the first bank, while a bench-side table of open rows predicts each sequence. A request pulsed during a busy burst is later checked to have left its own bank closed: the next access there must begin with an activate, not a precharge.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_PRE = 2'd3
  } dram_cmd_e;
endpackage

// File: rtl/bank_addr_map.sv
module bank_addr_map #(
  parameter int ROW_W   = 14,
  parameter int BANK_W  = 3,
  parameter int COL_W   = 11,
  parameter int BYTE_W  = 3,
  parameter int BURST_W = 3,
  localparam int ADDR_W = ROW_W + BANK_W + COL_W + BYTE_W,
  localparam int CHI_W  = COL_W - BURST_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              map_sel_i,
  input  logic              xor_en_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [CHI_W-1:0]  col_hi_o
);
  logic [BANK_W-1:0] bank_raw;
  logic              unused_low;

  assign row_o = addr_i[ADDR_W-1 -: ROW_W];

  always_comb begin
    if (map_sel_i) begin
      col_hi_o = addr_i[BYTE_W+BURST_W+BANK_W +: CHI_W];
      bank_raw = addr_i[BYTE_W+BURST_W +: BANK_W];
    end else begin
      col_hi_o = addr_i[BYTE_W+BURST_W +: CHI_W];
      bank_raw = addr_i[BYTE_W+COL_W +: BANK_W];
    end
  end

  // hash with low row bits
  assign bank_o = xor_en_i ? (bank_raw ^ row_o[BANK_W-1:0]) : bank_raw;

  // burst always starts at column offset zero
  assign unused_low = ^addr_i[BYTE_W+BURST_W-1:0];
endmodule

// File: rtl/bank_row_table.sv
module bank_row_table #(
  parameter int ROW_W  = 14,
  parameter int BANK_W = 3,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              pre_i,
  input  logic              rd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [BANK_W-1:0] lk_bank_i,
  output logic              lk_open_o,
  output logic [ROW_W-1:0]  lk_row_o
);
  logic [NUM_BANKS-1:0] open_q;
  logic [ROW_W-1:0]     row_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (bank_i == BANK_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end else if (sel && act_i) begin
        open_q[b] <= 1'b1;
        row_q[b]  <= row_i;
      end else if (sel && pre_i) begin
        open_q[b] <= 1'b0;
      end
    end
  end

  assign lk_open_o = open_q[lk_bank_i];
  assign lk_row_o  = row_q[lk_bank_i];

  assert_act_closed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> !open_q[bank_i]);
  assert_pre_open_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |-> open_q[bank_i]);
  assert_rd_open_row_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> (open_q[bank_i] && row_q[bank_i] == row_i));
endmodule

// File: rtl/bank_seq_fsm.sv
module bank_seq_fsm
  import bank_seq_pkg::*;
#(
  parameter int ROW_W   = 14,
  parameter int BANK_W  = 3,
  parameter int CHI_W   = 8,
  parameter int BURST_W = 3,
  parameter int T_RP    = 4,
  parameter int T_RCD   = 4,
  localparam int TMAX   = (T_RP > T_RCD) ? T_RP : T_RCD,
  localparam int CNT_W  = $clog2(TMAX + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [ROW_W-1:0]         dec_row_i,
  input  logic [BANK_W-1:0]        dec_bank_i,
  input  logic [CHI_W-1:0]         dec_col_hi_i,
  input  logic                     lk_open_i,
  input  logic [ROW_W-1:0]         lk_row_i,
  output logic                     ready_o,
  output dram_cmd_e                cmd_o,
  output logic [BANK_W-1:0]        bank_o,
  output logic [ROW_W-1:0]         row_o,
  output logic [CHI_W+BURST_W-1:0] col_o
);
  typedef enum logic [2:0] {S_IDLE, S_PRE, S_WRP, S_ACT, S_WRCD, S_RD} state_e;

  state_e             st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BURST_W-1:0] beat_q;
  logic [ROW_W-1:0]   row_q;
  logic [BANK_W-1:0]  bank_q;
  logic [CHI_W-1:0]   chi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      beat_q <= '0;
      row_q  <= '0;
      bank_q <= '0;
      chi_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (req_valid_i) begin
          row_q  <= dec_row_i;
          bank_q <= dec_bank_i;
          chi_q  <= dec_col_hi_i;
          beat_q <= '0;
          if (!lk_open_i)                st_q <= S_ACT;
          else if (lk_row_i == dec_row_i) st_q <= S_RD;
          else                            st_q <= S_PRE;
        end
        S_PRE: begin
          cnt_q <= CNT_W'(T_RP - 1);
          st_q  <= (T_RP <= 1) ? S_ACT : S_WRP;
        end
        S_WRP: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) st_q <= S_ACT;
        end
        S_ACT: begin
          cnt_q <= CNT_W'(T_RCD - 1);
          st_q  <= (T_RCD <= 1) ? S_RD : S_WRCD;
        end
        S_WRCD: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) st_q <= S_RD;
        end
        S_RD: begin
          beat_q <= beat_q + 1'b1;
          if (&beat_q) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      S_PRE:   cmd_o = CMD_PRE;
      S_ACT:   cmd_o = CMD_ACT;
      S_RD:    cmd_o = CMD_RD;
      default: cmd_o = CMD_NOP;
    endcase
  end

  assign ready_o = (st_q == S_IDLE);
  assign bank_o  = bank_q;
  assign row_o   = row_q;
  assign col_o   = {chi_q, beat_q};

  // checker state: cycles since previous command and its kind
  dram_cmd_e        last_q;
  logic [CNT_W-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= CMD_NOP;
      gap_q  <= '0;
    end else if (cmd_o != CMD_NOP) begin
      last_q <= cmd_o;
      gap_q  <= CNT_W'(1);
    end else if (gap_q != CNT_W'(TMAX)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assert_pre_act_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT && last_q == CMD_PRE) |-> gap_q == CNT_W'(T_RP));
  assert_act_rd_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_RD && last_q == CMD_ACT) |-> gap_q == CNT_W'(T_RCD));
  assert_busy_no_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != CMD_NOP) |-> !ready_o);
  assert_burst_steady_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_RD && col_o[BURST_W-1:0] != '1) |=>
      (cmd_o == CMD_RD && $stable(bank_o) && $stable(row_o)));
endmodule

// File: rtl/bank_cmd_seq.sv
module bank_cmd_seq
  import bank_seq_pkg::*;
#(
  parameter int ROW_W   = 14,
  parameter int BANK_W  = 3,
  parameter int COL_W   = 11,
  parameter int BYTE_W  = 3,
  parameter int BURST_W = 3,
  parameter int T_RP    = 4,
  parameter int T_RCD   = 4,
  localparam int ADDR_W = ROW_W + BANK_W + COL_W + BYTE_W,
  localparam int CHI_W  = COL_W - BURST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              map_sel_i,
  input  logic              xor_en_i,
  output logic              req_ready_o,
  output logic [1:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic [COL_W-1:0]  cmd_col_o
);
  logic [ROW_W-1:0]  dec_row, lk_row;
  logic [BANK_W-1:0] dec_bank;
  logic [CHI_W-1:0]  dec_chi;
  logic              lk_open;
  dram_cmd_e         cmd;

  bank_addr_map #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .BYTE_W(BYTE_W), .BURST_W(BURST_W)
  ) u_map (
    .addr_i(req_addr_i), .map_sel_i(map_sel_i), .xor_en_i(xor_en_i),
    .row_o(dec_row), .bank_o(dec_bank), .col_hi_o(dec_chi)
  );

  bank_row_table #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_tab (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .act_i(cmd == CMD_ACT), .pre_i(cmd == CMD_PRE), .rd_i(cmd == CMD_RD),
    .bank_i(cmd_bank_o), .row_i(cmd_row_o),
    .lk_bank_i(dec_bank), .lk_open_o(lk_open), .lk_row_o(lk_row)
  );

  bank_seq_fsm #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .CHI_W(CHI_W), .BURST_W(BURST_W),
    .T_RP(T_RP), .T_RCD(T_RCD)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .dec_row_i(dec_row), .dec_bank_i(dec_bank), .dec_col_hi_i(dec_chi),
    .lk_open_i(lk_open), .lk_row_i(lk_row),
    .ready_o(req_ready_o), .cmd_o(cmd),
    .bank_o(cmd_bank_o), .row_o(cmd_row_o), .col_o(cmd_col_o)
  );

  assign cmd_o = cmd;
endmodule

// File: tb/sim_bank_cmd_seq.sv
`timescale 1ns/1ps
module sim_bank_cmd_seq;
  localparam int TRP = 3;
  localparam int TRCD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [30:0] addr = '0;
  logic        map_sel = 1'b0;
  logic        xor_en = 1'b0;
  logic        ready;
  logic [1:0]  cmd;
  logic [2:0]  cbank;
  logic [13:0] crow;
  logic [10:0] ccol;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  bit        m_open [8];
  bit [13:0] m_row  [8];

  bank_cmd_seq #(.T_RP(TRP), .T_RCD(TRCD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_addr_i(addr),
    .map_sel_i(map_sel), .xor_en_i(xor_en), .req_ready_o(ready),
    .cmd_o(cmd), .cmd_bank_o(cbank), .cmd_row_o(crow), .cmd_col_o(ccol)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic [30:0] a_row(input [13:0] r, input [2:0] b, input [7:0] ch);
    return {r, b, ch, 6'd0};
  endfunction

  function automatic [30:0] a_blk(input [13:0] r, input [7:0] ch, input [2:0] b);
    return {r, ch, b, 6'd0};
  endfunction

  // one request: predict sequence from the bench table, capture, compare
  task automatic run_req(input [30:0] a, input bit m, input bit x, input string req,
                         input bit spam = 0, input [30:0] spam_a = '0);
    logic [2:0]  b;
    logic [13:0] r;
    logic [7:0]  ch;
    int          e_k [16];
    logic [1:0]  e_c [16];
    logic [10:0] e_col [16];
    int          n_e = 0;
    int          t = 1;
    int          c_k [32];
    logic [1:0]  c_c [32];
    logic [2:0]  c_b [32];
    logic [13:0] c_r [32];
    logic [10:0] c_col [32];
    int          n_c = 0;
    r  = a[30:17];
    b  = m ? a[8:6] : a[16:14];
    ch = m ? a[16:9] : a[13:6];
    if (x) b = b ^ r[2:0];
    if (m_open[b] && m_row[b] != r) begin
      e_k[n_e] = t; e_c[n_e] = 2'd3; e_col[n_e] = 'x; n_e++;
      t += TRP; m_open[b] = 0;
    end
    if (!m_open[b]) begin
      e_k[n_e] = t; e_c[n_e] = 2'd1; e_col[n_e] = 'x; n_e++;
      t += TRCD; m_open[b] = 1; m_row[b] = r;
    end
    for (int i = 0; i < 8; i++) begin
      e_k[n_e] = t + i; e_c[n_e] = 2'd2; e_col[n_e] = {ch, 3'(i)}; n_e++;
    end
    @(negedge clk);
    valid = 1; addr = a; map_sel = m; xor_en = x;
    check(ready === 1'b1, "R9", "ready before request", 64'(ready), 64'd1);
    @(posedge clk);
    for (int k = 1; k < 32; k++) begin
      @(negedge clk);
      valid = 0;
      if (spam && k == 2) begin valid = 1; addr = spam_a; map_sel = 0; xor_en = 0; end
      if (ready) break;
      if (cmd != 2'd0) begin
        c_k[n_c] = k; c_c[n_c] = cmd; c_b[n_c] = cbank; c_r[n_c] = crow;
        c_col[n_c] = ccol; n_c++;
      end
    end
    valid = 0;
    check(n_c == n_e, req, "command count", 64'(n_c), 64'(n_e));
    for (int i = 0; i < n_e && i < n_c; i++) begin
      bit ok;
      ok = c_k[i] == e_k[i] && c_c[i] == e_c[i] && c_b[i] == b &&
           (e_c[i] == 2'd3 || c_r[i] == r) && (e_c[i] != 2'd2 || c_col[i] == e_col[i]);
      check(ok, req, $sformatf("cmd %0d {cycle,cmd,bank,row,col}", i),
            {14'(c_k[i]), c_c[i], c_b[i], c_r[i], c_col[i]},
            {14'(e_k[i]), e_c[i], b, r, e_col[i]});
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_open[i] = 0; m_row[i] = '0; end
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ready === 1'b1 && cmd === 2'd0, "R1", "ready/cmd after reset",
          {ready, cmd}, {1'b1, 2'd0});
    // R2 R5 R8 closed bank, row-interleaved
    run_req(a_row(14'd5, 3'd2, 8'h35), 0, 0, "R5");
    // R6 same row hit
    run_req(a_row(14'd5, 3'd2, 8'h10), 0, 0, "R6");
    // R7 conflict in same bank
    run_req(a_row(14'd9, 3'd2, 8'h10), 0, 0, "R7");
    // R10 other bank, then bank 2 still open on row 9
    run_req(a_row(14'd7, 3'd4, 8'h00), 0, 0, "R10");
    run_req(a_row(14'd9, 3'd2, 8'h22), 0, 0, "R10");
    // R3 consecutive blocks in consecutive banks
    run_req(31'h40, 1, 0, "R3");
    run_req(31'h80, 1, 0, "R3");
    run_req(a_blk(14'd9, 8'hA5, 3'd4), 1, 0, "R3");
    // R4 xor hashing: bank 5 ^ row 3 -> bank 6
    run_req(a_row(14'd3, 3'd5, 8'h01), 0, 1, "R4");
    // R9 request during busy burst is ignored
    run_req(a_row(14'd3, 3'd5, 8'h02), 0, 1, "R9", 1, a_row(14'd100, 3'd0, 8'h00));
    @(negedge clk);
    check(ready === 1'b1 && cmd === 2'd0, "R9", "idle after ignored request",
          {ready, cmd}, {1'b1, 2'd0});
    run_req(a_row(14'd200, 3'd0, 8'h07), 0, 0, "R9");
    // R2 bank field at top of column range
    run_req(a_row(14'h3FFF, 3'd7, 8'hFF), 0, 0, "R2");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule